// File: doc/BRIEF.md
# Shared-Window Channel Configurator

This block lets a host set up eight monitor channels through a single shared set of staging registers. The host writes the thresholds, the interrupt and measurement enables, the interval choice and the target channel into the staging window. It sets a handshake flag and then issues a commit request. After a fixed latency the block copies a snapshot of the staged values into the named channel's slot and drops the handshake flag. The host polls that flag before it stages the next channel.

A converter outside the block delivers 16-bit results tagged with a channel number. Each result is stored for host reads. If the target channel is measuring, the result is also compared with the channel's committed thresholds. A result below the low threshold sets that channel's bit in the low status bitmap. A result above the high threshold sets its bit in the high status bitmap. The host clears status bits by writing ones to them. The interrupt line is raised by any status bit whose channel has both measurement and the matching interrupt enable set. A query port gives the converter's scheduler the committed thresholds and interval of any channel.

Top module: `cfgwin_top`

## Requirements
- R1: After reset, every readable register reads 0x00, the handshake flag is clear, no channel is measuring and irq is low.
- R2: Writes to the staging registers (0x41 channel control, 0x49/0x4A low threshold low/high byte, 0x4B/0x4C high threshold low/high byte, 0x4D enables, 0x50/0x51 period low/high byte) read back unchanged. Register 0x46 keeps only bit 7, the block enable.
- R3: Writing a byte with bit 0 set to 0x0D sets the handshake flag, which reads back as bit 0 of 0x0D. Once a commit request is accepted, the flag stays set after the accepting edge and the next one, and reads 0 after the second edge (COMMIT_LAT = 2).
- R4: A write to 0x47 is accepted as a commit request only if its bit 7 is 1, bit 7 of 0x46 is 1, the handshake flag is set and no commit is pending. Any other such write is ignored: the flag stays as it was and no channel slot changes.
- R5: A commit copies the staged low and high thresholds, the enables and the period into the slot of the channel named by 0x41 bits 7:5. It also copies the interval select from 0x41 bits 3:2 (0 = 50 ms, 1 = 100 ms, 2 = 1 s, 3 = period from 0x50/0x51). The slots of all other channels are unchanged.
- R6: A commit with 0x4D equal to zero turns the selected channel off (its bit in meas_en_o goes to 0).
- R7: Every result is stored for its channel, whether or not that channel is measuring. Channel n's low byte reads at 0xA0+2n and its high byte at 0xA1+2n.
- R8: For a channel whose 0x4D bit 7 (measure) was committed as 1, a result strictly below the low threshold sets status bit n at 0x0A, and a result strictly above the high threshold sets bit n at 0x0C. A result equal to a threshold, or any result for a channel that is not measuring, sets nothing.
- R9: Writing to 0x0A or 0x0C clears the status bits that are 1 in the written byte and leaves the other bits alone. If a set and a clear hit the same bit on the same edge, the set wins.
- R10: irq is high exactly when some measuring channel has its low status bit set with 0x4D bit 0 committed, or its high status bit set with 0x4D bit 1 committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| res_valid | input | 1 | Converter result strobe |
| res_ch | input | 3 | Channel of the result |
| res_data | input | 16 | Result value |
| qry_ch | input | 3 | Channel whose committed setup is shown |
| qry_lo_thr | output | 16 | Committed low threshold |
| qry_hi_thr | output | 16 | Committed high threshold |
| qry_isel | output | 2 | Committed interval select |
| qry_period | output | 16 | Committed period value |
| meas_en_o | output | 8 | Per-channel measurement enable |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and result strobes take effect on the edge that samples them, so status, stored results, irq and read-back are all checked in the low phase that follows that edge. The commit path is the only one with latency. The flag is sampled after the accepting edge, again one edge later while it must still be set, and again after the second edge, when it must be clear and the new slot contents must show on the query port and meas_en_o. Requests that must be ignored are followed by three idle edges, longer than the commit latency, before the flag and slots are checked.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
   localparam int VAL_W    = 16;
   localparam int CH_SEL_W = 3;

   localparam logic [7:0] A_STAT_LO = 8'h0A;
   localparam logic [7:0] A_STAT_HI = 8'h0C;
   localparam logic [7:0] A_HS      = 8'h0D;
   localparam logic [7:0] A_CTL     = 8'h41;
   localparam logic [7:0] A_EN      = 8'h46;
   localparam logic [7:0] A_REQ     = 8'h47;
   localparam logic [7:0] A_LO0     = 8'h49;
   localparam logic [7:0] A_LO1     = 8'h4A;
   localparam logic [7:0] A_HI0     = 8'h4B;
   localparam logic [7:0] A_HI1     = 8'h4C;
   localparam logic [7:0] A_IE      = 8'h4D;
   localparam logic [7:0] A_PER0    = 8'h50;
   localparam logic [7:0] A_PER1    = 8'h51;
   localparam logic [7:0] A_RES     = 8'hA0;

   typedef struct packed {
      logic [VAL_W-1:0] lo_thr;
      logic [VAL_W-1:0] hi_thr;
      logic [VAL_W-1:0] period;
      logic [1:0]       isel;
      logic             meas_en;
      logic             hi_ie;
      logic             lo_ie;
   } slot_t;
endpackage

// File: rtl/cfgwin_commit.sv
module cfgwin_commit
   import cfgwin_pkg::*;
#(
   parameter int COMMIT_LAT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hs_set_i,
   input  logic                req_i,
   input  logic                en_i,
   input  logic [CH_SEL_W-1:0] stage_ch_i,
   input  slot_t               stage_slot_i,
   output logic                hs_flag_o,
   output logic                commit_o,
   output logic [CH_SEL_W-1:0] commit_ch_o,
   output slot_t               commit_slot_o
);
   localparam int CNT_W = $clog2(COMMIT_LAT) + 1;

   logic                pend_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                flag_q;
   logic [CH_SEL_W-1:0] snap_ch_q;
   slot_t               snap_q;
   logic                accept;
   logic                fire;

   assign accept = req_i & en_i & flag_q & ~pend_q;
   assign fire   = pend_q & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         cnt_q     <= '0;
         snap_ch_q <= '0;
         snap_q    <= '0;
      end else if (accept) begin
         pend_q    <= 1'b1;
         cnt_q     <= CNT_W'(COMMIT_LAT - 1);
         snap_ch_q <= stage_ch_i;
         snap_q    <= stage_slot_i;
      end else if (pend_q) begin
         if (cnt_q == '0) pend_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   // the clear from a finishing commit takes priority over a host set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (fire)     flag_q <= 1'b0;
      else if (hs_set_i) flag_q <= 1'b1;
   end

   assign hs_flag_o     = flag_q;
   assign commit_o      = fire;
   assign commit_ch_o   = snap_ch_q;
   assign commit_slot_o = snap_q;

   AST_FLAG_DROPS_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !hs_flag_o); // R3
   AST_PENDING_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q < CNT_W'(COMMIT_LAT))); // R3
   AST_ACCEPT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> ($past(en_i) && $past(flag_q))); // R4
endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
   import cfgwin_pkg::*;
#(
   parameter int NCH     = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  commit_i,
   input  logic [CH_SEL_W-1:0]   commit_ch_i,
   input  slot_t                 commit_slot_i,
   input  logic                  res_valid_i,
   input  logic [CH_SEL_W-1:0]   res_ch_i,
   input  logic [VAL_W-1:0]      res_data_i,
   input  logic                  clr_lo_i,
   input  logic                  clr_hi_i,
   input  logic [NCH-1:0]        clr_mask_i,
   input  logic [CH_SEL_W-1:0]   qry_ch_i,
   output logic [VAL_W-1:0]      qry_lo_o,
   output logic [VAL_W-1:0]      qry_hi_o,
   output logic [1:0]            qry_isel_o,
   output logic [VAL_W-1:0]      qry_period_o,
   output logic [NCH-1:0]        stat_lo_o,
   output logic [NCH-1:0]        stat_hi_o,
   output logic [NCH*VAL_W-1:0]  res_flat_o,
   output logic [NCH-1:0]        meas_vec_o,
   output logic                  irq_o
);
   slot_t          slot_a [NCH];
   logic [NCH-1:0] src;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [CH_SEL_W-1:0] MY = CH_SEL_W'(g);
      slot_t            slot_r;
      logic [VAL_W-1:0] res_r;
      logic             lo_r, hi_r, hit, set_lo, set_hi;

      assign hit    = res_valid_i & (res_ch_i == MY);
      assign set_lo = hit & slot_r.meas_en & (res_data_i < slot_r.lo_thr);
      assign set_hi = hit & slot_r.meas_en & (res_data_i > slot_r.hi_thr);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_r <= '0;
            res_r  <= '0;
            lo_r   <= 1'b0;
            hi_r   <= 1'b0;
         end else begin
            if (commit_i && commit_ch_i == MY) slot_r <= commit_slot_i;
            if (hit) res_r <= res_data_i;
            lo_r <= set_lo | (lo_r & ~(clr_lo_i & clr_mask_i[g]));
            hi_r <= set_hi | (hi_r & ~(clr_hi_i & clr_mask_i[g]));
         end
      end

      assign slot_a[g]                  = slot_r;
      assign res_flat_o[g*VAL_W +: VAL_W] = res_r;
      assign stat_lo_o[g]               = lo_r;
      assign stat_hi_o[g]               = hi_r;
      assign meas_vec_o[g]              = slot_r.meas_en;
      assign src[g] = slot_r.meas_en & ((lo_r & slot_r.lo_ie) | (hi_r & slot_r.hi_ie));

      AST_RESULT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
         hit |=> (res_r == $past(res_data_i))); // R7
      AST_IDLE_CH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !slot_r.meas_en && !lo_r && !hi_r) |=> (!lo_r && !hi_r)); // R8
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_lo_i && clr_mask_i[g] && !hit) |=> !lo_r); // R9
   end

   always_comb begin
      qry_lo_o     = '0;
      qry_hi_o     = '0;
      qry_isel_o   = '0;
      qry_period_o = '0;
      for (int i = 0; i < NCH; i++) begin
         if (qry_ch_i == CH_SEL_W'(i)) begin
            qry_lo_o     = slot_a[i].lo_thr;
            qry_hi_o     = slot_a[i].hi_thr;
            qry_isel_o   = slot_a[i].isel;
            qry_period_o = slot_a[i].period;
         end
      end
   end

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |src;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |src;
      AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> ((|stat_lo_o) || (|stat_hi_o))); // R10
   end
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
   import cfgwin_pkg::*;
#(
   parameter int NCH        = 8,
   parameter int COMMIT_LAT = 2,
   parameter bit REG_IRQ    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [7:0]          reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   input  logic                res_valid,
   input  logic [CH_SEL_W-1:0] res_ch,
   input  logic [VAL_W-1:0]    res_data,
   input  logic [CH_SEL_W-1:0] qry_ch,
   output logic [VAL_W-1:0]    qry_lo_thr,
   output logic [VAL_W-1:0]    qry_hi_thr,
   output logic [1:0]          qry_isel,
   output logic [VAL_W-1:0]    qry_period,
   output logic [NCH-1:0]      meas_en_o,
   output logic                irq
);
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("cfgwin_top: NCH must be between 1 and 8");
   end
   if (COMMIT_LAT < 1) begin : g_bad_lat
      $error("cfgwin_top: COMMIT_LAT must be at least 1");
   end
   if (VAL_W != 16) begin : g_bad_w
      $error("cfgwin_top: results are read as two bytes");
   end

   logic [7:0] ctl_q, ie_q, lo0_q, lo1_q, hi0_q, hi1_q, per0_q, per1_q;
   logic       en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0; ie_q   <= '0; en_q   <= 1'b0;
         lo0_q  <= '0; lo1_q  <= '0; hi0_q  <= '0; hi1_q <= '0;
         per0_q <= '0; per1_q <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            A_CTL:  ctl_q  <= reg_wdata;
            A_EN:   en_q   <= reg_wdata[7];
            A_LO0:  lo0_q  <= reg_wdata;
            A_LO1:  lo1_q  <= reg_wdata;
            A_HI0:  hi0_q  <= reg_wdata;
            A_HI1:  hi1_q  <= reg_wdata;
            A_IE:   ie_q   <= reg_wdata;
            A_PER0: per0_q <= reg_wdata;
            A_PER1: per1_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   slot_t stage_slot;
   always_comb begin
      stage_slot.lo_thr  = {lo1_q, lo0_q};
      stage_slot.hi_thr  = {hi1_q, hi0_q};
      stage_slot.period  = {per1_q, per0_q};
      stage_slot.isel    = ctl_q[3:2];
      stage_slot.meas_en = ie_q[7];
      stage_slot.hi_ie   = ie_q[1];
      stage_slot.lo_ie   = ie_q[0];
   end

   logic                hs_flag, commit;
   logic [CH_SEL_W-1:0] commit_ch;
   slot_t               commit_slot;

   cfgwin_commit #(.COMMIT_LAT(COMMIT_LAT)) u_commit (
      .clk          (clk),
      .rst_n        (rst_n),
      .hs_set_i     (reg_we && reg_addr == A_HS && reg_wdata[0]),
      .req_i        (reg_we && reg_addr == A_REQ && reg_wdata[7]),
      .en_i         (en_q),
      .stage_ch_i   (ctl_q[7:5]),
      .stage_slot_i (stage_slot),
      .hs_flag_o    (hs_flag),
      .commit_o     (commit),
      .commit_ch_o  (commit_ch),
      .commit_slot_o(commit_slot)
   );

   logic [NCH-1:0]       stat_lo, stat_hi;
   logic [NCH*VAL_W-1:0] res_flat;

   cfgwin_bank #(.NCH(NCH), .REG_IRQ(REG_IRQ)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_i     (commit),
      .commit_ch_i  (commit_ch),
      .commit_slot_i(commit_slot),
      .res_valid_i  (res_valid),
      .res_ch_i     (res_ch),
      .res_data_i   (res_data),
      .clr_lo_i     (reg_we && reg_addr == A_STAT_LO),
      .clr_hi_i     (reg_we && reg_addr == A_STAT_HI),
      .clr_mask_i   (reg_wdata[NCH-1:0]),
      .qry_ch_i     (qry_ch),
      .qry_lo_o     (qry_lo_thr),
      .qry_hi_o     (qry_hi_thr),
      .qry_isel_o   (qry_isel),
      .qry_period_o (qry_period),
      .stat_lo_o    (stat_lo),
      .stat_hi_o    (stat_hi),
      .res_flat_o   (res_flat),
      .meas_vec_o   (meas_en_o),
      .irq_o        (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_STAT_LO: reg_rdata[NCH-1:0] = stat_lo;
         A_STAT_HI: reg_rdata[NCH-1:0] = stat_hi;
         A_HS:      reg_rdata[0]       = hs_flag;
         A_CTL:     reg_rdata = ctl_q;
         A_EN:      reg_rdata[7] = en_q;
         A_LO0:     reg_rdata = lo0_q;
         A_LO1:     reg_rdata = lo1_q;
         A_HI0:     reg_rdata = hi0_q;
         A_HI1:     reg_rdata = hi1_q;
         A_IE:      reg_rdata = ie_q;
         A_PER0:    reg_rdata = per0_q;
         A_PER1:    reg_rdata = per1_q;
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (reg_addr == 8'(A_RES + 2*i))     reg_rdata = res_flat[i*VAL_W +: 8];
               if (reg_addr == 8'(A_RES + 2*i + 1)) reg_rdata = res_flat[i*VAL_W+8 +: 8];
            end
         end
      endcase
   end

   AST_NO_IRQ_AT_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq); // R1
endmodule

// File: tb/tb_cfgwin_top.sv
module tb_cfgwin_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        res_valid = 1'b0;
   logic [2:0]  res_ch = '0;
   logic [15:0] res_data = '0;
   logic [2:0]  qry_ch = '0;
   logic [15:0] qry_lo_thr, qry_hi_thr, qry_period;
   logic [1:0]  qry_isel;
   logic [7:0]  meas_en_o;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   cfgwin_top dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid),
      .res_ch(res_ch), .res_data(res_data), .qry_ch(qry_ch),
      .qry_lo_thr(qry_lo_thr), .qry_hi_thr(qry_hi_thr), .qry_isel(qry_isel),
      .qry_period(qry_period), .meas_en_o(meas_en_o), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // all tasks start just after a falling edge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
   endtask

   task automatic push(input logic [2:0] c, input logic [15:0] d);
      res_valid = 1'b1; res_ch = c; res_data = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic commit_now();
      wr(8'h0D, 8'h01);
      wr(8'h47, 8'h80);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      rd_chk("R1 flag", 8'h0D, 8'h00);
      rd_chk("R1 low status", 8'h0A, 8'h00);
      rd_chk("R1 high status", 8'h0C, 8'h00);
      rd_chk("R1 ctl", 8'h41, 8'h00);
      rd_chk("R1 result", 8'hA0, 8'h00);
      chk("R1 meas", {8'h00, meas_en_o}, 16'h0000);
      chk("R1 irq", {15'h0, irq}, 16'h0000);
   endtask

   task automatic t_staging();
      wr(8'h49, 8'h00); wr(8'h4A, 8'h01);
      wr(8'h4B, 8'h00); wr(8'h4C, 8'h0F);
      wr(8'h50, 8'h34); wr(8'h51, 8'h12);
      wr(8'h41, 8'hAC); wr(8'h4D, 8'h83);
      wr(8'h46, 8'hFF);
      rd_chk("R2 low thr hi byte", 8'h4A, 8'h01);
      rd_chk("R2 high thr hi byte", 8'h4C, 8'h0F);
      rd_chk("R2 period lo", 8'h50, 8'h34);
      rd_chk("R2 ctl", 8'h41, 8'hAC);
      rd_chk("R2 enable keeps bit7", 8'h46, 8'h80);
   endtask

   task automatic t_commit();
      wr(8'h0D, 8'h01);
      rd_chk("R3 flag set", 8'h0D, 8'h01);
      wr(8'h47, 8'h80);
      rd_chk("R3 flag after accept", 8'h0D, 8'h01);
      @(negedge clk);
      rd_chk("R3 flag one edge later", 8'h0D, 8'h01);
      @(negedge clk);
      rd_chk("R3 flag cleared", 8'h0D, 8'h00);
      chk("R5 meas ch5", {8'h00, meas_en_o}, 16'h0020);
      qry_ch = 3'd5; #1;
      chk("R5 low thr", qry_lo_thr, 16'h0100);
      chk("R5 high thr", qry_hi_thr, 16'h0F00);
      chk("R5 isel", {14'h0, qry_isel}, 16'h0003);
      chk("R5 period", qry_period, 16'h1234);
      qry_ch = 3'd4; #1;
      chk("R5 other channel untouched", qry_lo_thr, 16'h0000);
   endtask

   task automatic t_ignored();
      wr(8'h4D, 8'h00);
      wr(8'h47, 8'h80);
      repeat (3) @(negedge clk);
      chk("R4 no flag ignored", {8'h00, meas_en_o}, 16'h0020);
      wr(8'h46, 8'h00);
      wr(8'h0D, 8'h01);
      wr(8'h47, 8'h80);
      repeat (3) @(negedge clk);
      rd_chk("R4 disabled keeps flag", 8'h0D, 8'h01);
      chk("R4 disabled no commit", {8'h00, meas_en_o}, 16'h0020);
      wr(8'h46, 8'h80);
      wr(8'h47, 8'h01);
      repeat (3) @(negedge clk);
      rd_chk("R4 bit7 clear keeps flag", 8'h0D, 8'h01);
      chk("R4 bit7 clear no commit", {8'h00, meas_en_o}, 16'h0020);
      wr(8'h47, 8'h80);
      repeat (2) @(negedge clk);
      chk("R6 channel disabled", {8'h00, meas_en_o}, 16'h0000);
   endtask

   task automatic t_status();
      wr(8'h4D, 8'h83);
      commit_now();
      chk("R6 re-enabled", {8'h00, meas_en_o}, 16'h0020);
      push(3'd5, 16'h0080);
      rd_chk("R8 low set", 8'h0A, 8'h20);
      rd_chk("R7 result lo", 8'hAA, 8'h80);
      rd_chk("R7 result hi", 8'hAB, 8'h00);
      chk("R10 irq low", {15'h0, irq}, 16'h0001);
      wr(8'h0A, 8'h01);
      rd_chk("R9 other bit kept", 8'h0A, 8'h20);
      wr(8'h0A, 8'h20);
      rd_chk("R9 cleared", 8'h0A, 8'h00);
      chk("R10 irq drops", {15'h0, irq}, 16'h0000);
      push(3'd5, 16'h0100);
      rd_chk("R8 equal low", 8'h0A, 8'h00);
      push(3'd5, 16'h0F00);
      rd_chk("R8 equal high", 8'h0C, 8'h00);
      push(3'd5, 16'h0F01);
      rd_chk("R8 high set", 8'h0C, 8'h20);
      chk("R10 irq high", {15'h0, irq}, 16'h0001);
      wr(8'h4D, 8'h81);
      commit_now();
      chk("R10 high int masked", {15'h0, irq}, 16'h0000);
      rd_chk("R10 status kept", 8'h0C, 8'h20);
      push(3'd2, 16'h1234);
      rd_chk("R8 idle channel silent", 8'h0A, 8'h00);
      rd_chk("R7 idle result lo", 8'hA4, 8'h34);
      rd_chk("R7 idle result hi", 8'hA5, 8'h12);
      reg_we = 1'b1; reg_addr = 8'h0A; reg_wdata = 8'h20;
      res_valid = 1'b1; res_ch = 3'd5; res_data = 16'h0010;
      @(negedge clk);
      reg_we = 1'b0; res_valid = 1'b0;
      rd_chk("R9 set wins", 8'h0A, 8'h20);
   endtask

   task automatic t_second_channel();
      wr(8'h41, 8'h04);
      wr(8'h49, 8'h00); wr(8'h4A, 8'h02);
      wr(8'h4D, 8'h80);
      commit_now();
      chk("R5 two channels", {8'h00, meas_en_o}, 16'h0021);
      qry_ch = 3'd0; #1;
      chk("R5 ch0 isel", {14'h0, qry_isel}, 16'h0001);
      chk("R5 ch0 low thr", qry_lo_thr, 16'h0200);
      qry_ch = 3'd5; #1;
      chk("R5 ch5 unchanged", qry_lo_thr, 16'h0100);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_staging();
      t_commit();
      t_ignored();
      t_status();
      t_second_channel();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule